// File: doc/BRIEF.md
# Two-Entry Operand-Snooping Reservation Station

This block sits in front of one integer execution unit and holds up to two operations that have been dispatched but cannot yet run. Each source operand arrives at dispatch either as a value, read from the architected registers or the rename buffers, or as a pending producer tag.

While an operand is pending, the station compares its tag against all three result buses every cycle. When a bus carries that tag, the station latches the value straight off the bus. An operation is offered to the execution unit once every source it needs holds a value.

The station raises a full flag toward dispatch when both slots are occupied. When both slots are ready, it offers the older operation first. A flush from branch recovery removes every held operation whose completion-queue index is younger than the mispredicted branch.

Top module: `rs_two_entry`

## Requirements
- R1: After synchronous reset, both slots are empty, `full` is 0 and `iss_valid` is 0.
- R2: An operation dispatched with all sources marked valid is offered on the cycle after dispatch. `iss_op` and `iss_qidx` carry the dispatched values. Source n's data appears at `iss_src_data[n*32 +: 32]`.
- R3: A pending source is filled from whichever of the three result buses is valid and carries a matching tag. Bus n uses `bus_tag[n*4 +: 4]` and `bus_data[n*32 +: 32]`. A bus that is not valid, or that carries a different tag, has no effect.
- R4: A held operation is not offered while any of its sources is still pending.
- R5: A source whose tag is on a valid result bus in the same cycle it is dispatched is captured in that cycle. The operation is then offered on the next cycle.
- R6: `full` is 1 exactly when both slots are occupied. A dispatch presented while `full` is 1 is dropped and never issues.
- R7: When both slots are ready, the one dispatched earlier is offered first, and at most one operation is offered per cycle.
- R8: The offered operation leaves the station only on a cycle where `unit_ready` is 1. While `unit_ready` is 0, `iss_valid` stays 1.
- R9: A cycle with `flush_valid` high empties each slot whose index q is younger than `flush_qidx`. Younger means (q - flush_qidx) mod 16 lies in 1..7. Slots with older or equal indices stay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch presents an operation |
| disp_op | input | 8 | Operation code |
| disp_qidx | input | 4 | Completion-queue index of the operation |
| disp_src_valid | input | 2 | Per source: 1 means value given, 0 means tag pending |
| disp_src_tag | input | 8 | Per-source producer tag, 4 bits each |
| disp_src_data | input | 64 | Per-source value, 32 bits each |
| bus_valid | input | 3 | Result bus carries a result |
| bus_tag | input | 12 | Result bus tags, 4 bits each |
| bus_data | input | 96 | Result bus values, 32 bits each |
| flush_valid | input | 1 | Branch recovery flush |
| flush_qidx | input | 4 | Completion-queue index of the mispredicted branch |
| unit_ready | input | 1 | Execution unit accepts the offered operation |
| full | output | 1 | Both slots occupied |
| iss_valid | output | 1 | An operation is offered |
| iss_op | output | 8 | Offered operation code |
| iss_qidx | output | 4 | Offered completion-queue index |
| iss_src_data | output | 64 | Offered source values |

## Verification
On every cycle, the assertions check the following:
- the post-reset state is empty;
- `full` persists while nothing leaves;
- a stalled offer stays up;
- the selector grants at most one slot and never passes over a ready older slot.

Some behaviours need the bench's scenarios to show them:
- the value captured from each particular bus;
- decoy buses being ignored;
- same-cycle capture at dispatch;
- dropped dispatches while full;
- wrap-aware flush of younger slots;
- the exact issue order of two operations woken together.

// File: rtl/rs_pkg.sv
package rs_pkg;
    parameter int TAG_W   = 4;
    parameter int DATA_W  = 32;
    parameter int NUM_BUS = 3;
    parameter int NUM_SRC = 2;
    parameter int QIDX_W  = 4;
    parameter int OP_W    = 8;
    parameter int NUM_ENT = 2;
    localparam int ENT_IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [QIDX_W-1:0] qidx_t;
    typedef logic [OP_W-1:0]   op_t;

    typedef struct packed {
        logic  rdy;
        tag_t  tag;
        data_t val;
    } opnd_t;

    typedef struct packed {
        logic  vld;
        tag_t  tag;
        data_t val;
    } rbus_t;

    typedef struct packed {
        logic                busy;
        op_t                 op;
        qidx_t               qidx;
        opnd_t [NUM_SRC-1:0] src;
    } slot_t;

    // True when index a lies strictly after ref_q in the circular queue.
    function automatic logic is_younger(qidx_t a, qidx_t ref_q);
        qidx_t d;
        d = a - ref_q;
        return (d != '0) && !d[QIDX_W-1];
    endfunction
endpackage

// File: rtl/rs_snoop.sv
module rs_snoop import rs_pkg::*; (
    input  opnd_t                cur,
    input  rbus_t [NUM_BUS-1:0]  buses,
    output opnd_t                nxt
);
    logic hit;

    always_comb begin
        nxt = cur;
        hit = 1'b0;
        for (int b = 0; b < NUM_BUS; b++) begin
            if (!cur.rdy && !hit && buses[b].vld && (buses[b].tag == cur.tag)) begin
                nxt.rdy = 1'b1;
                nxt.val = buses[b].val;
                hit     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_slot.sv
module rs_slot import rs_pkg::*; (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  slot_t               load_val,
    input  logic                clear,
    input  rbus_t [NUM_BUS-1:0] buses,
    output slot_t               slot,
    output logic                ready
);
    opnd_t [NUM_SRC-1:0] snooped;
    logic  [NUM_SRC-1:0] src_rdy;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        rs_snoop u_snoop (
            .cur   (slot.src[s]),
            .buses (buses),
            .nxt   (snooped[s])
        );
        assign src_rdy[s] = slot.src[s].rdy;
    end

    assign ready = slot.busy && (&src_rdy);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (load) begin
            slot <= load_val;
        end else if (clear) begin
            slot.busy <= 1'b0;
        end else if (slot.busy) begin
            slot.src <= snooped;
        end
    end
endmodule

// File: rtl/rs_issue_sel.sv
module rs_issue_sel import rs_pkg::*; (
    input  logic [NUM_ENT-1:0]   ready,
    input  logic [ENT_IDX_W-1:0] oldest,
    output logic [NUM_ENT-1:0]   grant,
    output logic [ENT_IDX_W-1:0] gidx,
    output logic                 any
);
    logic [ENT_IDX_W-1:0] k;

    always_comb begin
        grant = '0;
        gidx  = '0;
        any   = 1'b0;
        k     = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            k = ENT_IDX_W'((int'(oldest) + i) % NUM_ENT);
            if (!any && ready[k]) begin
                any      = 1'b1;
                gidx     = k;
                grant[k] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_two_entry.sv
module rs_two_entry import rs_pkg::*; (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      disp_valid,
    input  logic [OP_W-1:0]           disp_op,
    input  logic [QIDX_W-1:0]         disp_qidx,
    input  logic [NUM_SRC-1:0]        disp_src_valid,
    input  logic [NUM_SRC*TAG_W-1:0]  disp_src_tag,
    input  logic [NUM_SRC*DATA_W-1:0] disp_src_data,
    input  logic [NUM_BUS-1:0]        bus_valid,
    input  logic [NUM_BUS*TAG_W-1:0]  bus_tag,
    input  logic [NUM_BUS*DATA_W-1:0] bus_data,
    input  logic                      flush_valid,
    input  logic [QIDX_W-1:0]         flush_qidx,
    input  logic                      unit_ready,
    output logic                      full,
    output logic                      iss_valid,
    output logic [OP_W-1:0]           iss_op,
    output logic [QIDX_W-1:0]         iss_qidx,
    output logic [NUM_SRC*DATA_W-1:0] iss_src_data
);
    rbus_t [NUM_BUS-1:0]  buses;
    opnd_t [NUM_SRC-1:0]  disp_raw;
    opnd_t [NUM_SRC-1:0]  disp_snp;
    slot_t                new_slot;
    slot_t [NUM_ENT-1:0]  slots;
    logic  [NUM_ENT-1:0]  busy;
    logic  [NUM_ENT-1:0]  ready;
    logic  [NUM_ENT-1:0]  load;
    logic  [NUM_ENT-1:0]  clear;
    logic  [NUM_ENT-1:0]  busy_nxt;
    logic  [NUM_ENT-1:0]  grant;
    logic  [ENT_IDX_W-1:0] gidx;
    logic  [ENT_IDX_W-1:0] free_idx;
    logic  [ENT_IDX_W-1:0] oldest;
    logic                 accept;
    logic                 fire;
    logic                 any_rdy;

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        assign buses[b].vld = bus_valid[b];
        assign buses[b].tag = bus_tag[b*TAG_W +: TAG_W];
        assign buses[b].val = bus_data[b*DATA_W +: DATA_W];
    end

    // Dispatch-time snoop so a result on a bus this cycle is not missed.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_dsrc
        assign disp_raw[s].rdy = disp_src_valid[s];
        assign disp_raw[s].tag = disp_src_tag[s*TAG_W +: TAG_W];
        assign disp_raw[s].val = disp_src_data[s*DATA_W +: DATA_W];
        rs_snoop u_dsnoop (
            .cur   (disp_raw[s]),
            .buses (buses),
            .nxt   (disp_snp[s])
        );
        assign iss_src_data[s*DATA_W +: DATA_W] = slots[gidx].src[s].val;
    end

    always_comb begin
        new_slot.busy = 1'b1;
        new_slot.op   = disp_op;
        new_slot.qidx = disp_qidx;
        new_slot.src  = disp_snp;
    end

    always_comb begin
        free_idx = '0;
        for (int e = NUM_ENT - 1; e >= 0; e--) begin
            if (!busy[e]) free_idx = ENT_IDX_W'(e);
        end
    end

    assign full   = &busy;
    assign accept = disp_valid && !full;
    assign fire   = any_rdy && unit_ready;

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_slot
        assign load[e]  = accept && (free_idx == ENT_IDX_W'(e));
        assign clear[e] = (fire && grant[e]) ||
                          (flush_valid && busy[e] && is_younger(slots[e].qidx, flush_qidx));
        assign busy[e]     = slots[e].busy;
        assign busy_nxt[e] = load[e] || (busy[e] && !clear[e]);

        rs_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .load     (load[e]),
            .load_val (new_slot),
            .clear    (clear[e]),
            .buses    (buses),
            .slot     (slots[e]),
            .ready    (ready[e])
        );
    end

    rs_issue_sel u_sel (
        .ready  (ready),
        .oldest (oldest),
        .grant  (grant),
        .gidx   (gidx),
        .any    (any_rdy)
    );

    // Age pointer: index of the slot dispatched earlier.
    always_ff @(posedge clk) begin
        if (rst) begin
            oldest <= '0;
        end else if (accept) begin
            oldest <= busy_nxt[~free_idx] ? ~free_idx : free_idx;
        end else if (!busy_nxt[oldest]) begin
            oldest <= ~oldest;
        end
    end

    assign iss_valid = any_rdy;
    assign iss_op    = slots[gidx].op;
    assign iss_qidx  = slots[gidx].qidx;
endmodule

// File: rtl/rs_two_entry_chk.sv
module rs_two_entry_chk import rs_pkg::*; (
    input logic                 clk,
    input logic                 rst,
    input logic                 full,
    input logic                 iss_valid,
    input logic                 unit_ready,
    input logic                 flush_valid,
    input logic [NUM_ENT-1:0]   busy,
    input logic [NUM_ENT-1:0]   ready,
    input logic [NUM_ENT-1:0]   grant,
    input logic [ENT_IDX_W-1:0] oldest
);
    // R1
    reset_empty_chk: assert property (@(posedge clk) $fell(rst) |-> (!full && !iss_valid));

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !(iss_valid && unit_ready) && !flush_valid) |=> full);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !unit_ready && !flush_valid) |=> iss_valid);

    // R7
    one_grant_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));

    // R7
    age_order_chk: assert property (@(posedge clk) disable iff (rst)
        (grant[~oldest] && busy[oldest]) |-> !ready[oldest]);

    // R4
    grant_ready_chk: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> ($countones(ready) >= 1));
endmodule

bind rs_two_entry rs_two_entry_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .full        (full),
    .iss_valid   (iss_valid),
    .unit_ready  (unit_ready),
    .flush_valid (flush_valid),
    .busy        (busy),
    .ready       (ready),
    .grant       (grant),
    .oldest      (oldest)
);

// File: tb/sim_rs_two_entry.sv
`timescale 1ns/1ps
module sim_rs_two_entry;
    logic        clk = 1'b0;
    logic        rst;
    logic        disp_valid;
    logic [7:0]  disp_op;
    logic [3:0]  disp_qidx;
    logic [1:0]  disp_src_valid;
    logic [7:0]  disp_src_tag;
    logic [63:0] disp_src_data;
    logic [2:0]  bus_valid;
    logic [11:0] bus_tag;
    logic [95:0] bus_data;
    logic        flush_valid;
    logic [3:0]  flush_qidx;
    logic        unit_ready;
    logic        full;
    logic        iss_valid;
    logic [7:0]  iss_op;
    logic [3:0]  iss_qidx;
    logic [63:0] iss_src_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    rs_two_entry u0 (
        .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_qidx(disp_qidx), .disp_src_valid(disp_src_valid),
        .disp_src_tag(disp_src_tag), .disp_src_data(disp_src_data),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .flush_valid(flush_valid), .flush_qidx(flush_qidx),
        .unit_ready(unit_ready), .full(full), .iss_valid(iss_valid),
        .iss_op(iss_op), .iss_qidx(iss_qidx), .iss_src_data(iss_src_data)
    );

    // {bus index, tag, src0 value, src1 value}
    localparam logic [69:0] VEC [4] = '{
        {2'd0, 4'd3, 32'h1111_0000, 32'hAAAA_0001},
        {2'd1, 4'd7, 32'h2222_0000, 32'hBBBB_0002},
        {2'd2, 4'd12, 32'h3333_0000, 32'hCCCC_0003},
        {2'd1, 4'd0, 32'h4444_0000, 32'hDDDD_0004}
    };

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_bus(int b, logic v, logic [3:0] t, logic [31:0] d);
        bus_valid[b]        = v;
        bus_tag[b*4 +: 4]   = t;
        bus_data[b*32 +: 32] = d;
    endtask

    task automatic clr_bus();
        bus_valid = '0; bus_tag = '0; bus_data = '0;
    endtask

    task automatic disp(logic [7:0] op, logic [3:0] q,
                        logic v0, logic [3:0] t0, logic [31:0] d0,
                        logic v1, logic [3:0] t1, logic [31:0] d1);
        disp_valid = 1'b1; disp_op = op; disp_qidx = q;
        disp_src_valid = {v1, v0};
        disp_src_tag   = {t1, t0};
        disp_src_data  = {d1, d0};
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1; disp_valid = 0; disp_op = 0; disp_qidx = 0;
        disp_src_valid = 0; disp_src_tag = 0; disp_src_data = 0;
        flush_valid = 0; flush_qidx = 0; unit_ready = 0;
        clr_bus();
        repeat (3) tick();
        rst = 0;
        tick();
        chk("R1 full", full, 0);
        chk("R1 iss_valid", iss_valid, 0);

        // R2: all sources valid at dispatch, issue next cycle
        disp(8'h55, 4'd9, 1, 0, 32'h0BAD_F00D, 1, 0, 32'h1234_5678);
        tick();
        disp_valid = 0;
        chk("R2 iss_valid", iss_valid, 1);
        chk("R2 iss_op", iss_op, 8'h55);
        chk("R2 iss_qidx", iss_qidx, 4'd9);
        chk("R2 data", iss_src_data, {32'h1234_5678, 32'h0BAD_F00D});
        unit_ready = 1;
        tick();
        unit_ready = 0;
        chk("R8 consumed", iss_valid, 0);

        // Table walk: R3/R4 capture from each bus with decoys
        for (int k = 0; k < 4; k++) begin
            logic [1:0]  b;
            logic [3:0]  t;
            logic [31:0] d0, d1;
            {b, t, d0, d1} = VEC[k];
            disp(8'h10 + 8'(k), 4'(k), 1, 0, d0, 0, t, 32'h0);
            tick();
            disp_valid = 0;
            chk("R4 pending no issue", iss_valid, 0);
            set_bus(int'(b), 0, t, 32'hDEAD_0000);
            set_bus((int'(b) + 1) % 3, 1, t ^ 4'h1, 32'hDEAD_0001);
            tick();
            chk("R3 decoy ignored", iss_valid, 0);
            clr_bus();
            set_bus(int'(b), 1, t, d1);
            tick();
            clr_bus();
            chk("R3 captured valid", iss_valid, 1);
            chk("R3 captured data", iss_src_data, {d1, d0});
            chk("R3 op", iss_op, 8'h10 + 8'(k));
            unit_ready = 1;
            tick();
            unit_ready = 0;
            chk("R8 drained", iss_valid, 0);
        end

        // R5: same-cycle capture at dispatch
        disp(8'h21, 4'd4, 1, 0, 32'hCAFE_0000, 0, 4'd5, 32'h0);
        set_bus(2, 1, 4'd5, 32'h5555_AAAA);
        tick();
        disp_valid = 0; clr_bus();
        chk("R5 iss_valid", iss_valid, 1);
        chk("R5 data", iss_src_data, {32'h5555_AAAA, 32'hCAFE_0000});
        unit_ready = 1;
        tick();
        unit_ready = 0;

        // R6/R7/R8: fill, refuse, wake both, older first
        disp(8'h31, 4'd6, 0, 4'd2, 32'h0, 1, 0, 32'h6);
        tick();
        disp(8'h32, 4'd7, 0, 4'd3, 32'h0, 1, 0, 32'h7);
        tick();
        chk("R6 full set", full, 1);
        disp(8'h33, 4'd8, 1, 0, 32'h8, 1, 0, 32'h8);
        tick();
        disp_valid = 0;
        chk("R6 still full", full, 1);
        chk("R6 refused no issue", iss_valid, 0);
        set_bus(0, 1, 4'd3, 32'hB0B0_0003);
        set_bus(1, 1, 4'd2, 32'hA0A0_0002);
        tick();
        clr_bus();
        chk("R7 older first", iss_qidx, 4'd6);
        chk("R7 older data", iss_src_data, {32'h6, 32'hA0A0_0002});
        tick();
        chk("R8 stall holds valid", iss_valid, 1);
        chk("R8 stall holds qidx", iss_qidx, 4'd6);
        unit_ready = 1;
        tick();
        chk("R7 younger next", iss_qidx, 4'd7);
        chk("R7 younger data", iss_src_data, {32'h7, 32'hB0B0_0003});
        tick();
        unit_ready = 0;
        chk("R6 refused never issues", iss_valid, 0);
        chk("R6 empty", full, 0);

        // R9: flush younger than 4 removes 5, keeps 3
        disp(8'h41, 4'd3, 0, 4'd9, 32'h0, 1, 0, 32'h3);
        tick();
        disp(8'h42, 4'd5, 0, 4'd10, 32'h0, 1, 0, 32'h5);
        tick();
        disp_valid = 0;
        flush_valid = 1; flush_qidx = 4'd4;
        tick();
        flush_valid = 0;
        chk("R9 slot freed", full, 0);
        set_bus(0, 1, 4'd9, 32'h9);
        set_bus(1, 1, 4'd10, 32'hA);
        tick();
        clr_bus();
        chk("R9 older kept", iss_qidx, 4'd3);
        chk("R9 older kept valid", iss_valid, 1);
        unit_ready = 1;
        tick();
        unit_ready = 0;
        chk("R9 younger gone", iss_valid, 0);

        // R9: wrap-around, both 15 and 1 are younger than 14
        disp(8'h51, 4'd15, 0, 4'd11, 32'h0, 1, 0, 32'h1);
        tick();
        disp(8'h52, 4'd1, 0, 4'd12, 32'h0, 1, 0, 32'h2);
        tick();
        disp_valid = 0;
        flush_valid = 1; flush_qidx = 4'd14;
        tick();
        flush_valid = 0;
        chk("R9 wrap full clear", full, 0);
        set_bus(0, 1, 4'd11, 32'hB);
        set_bus(2, 1, 4'd12, 32'hC);
        tick();
        clr_bus();
        chk("R9 wrap none issue", iss_valid, 0);

        finish_run();
    end
endmodule